// File: doc/BRIEF.md
# Shared-Port Indexed Register Bank with Phase Toggle

This block is a bank of byte-wide registers that software reaches through a single write port. An internal phase flip-flop decides what each write means. In index phase, the written byte selects a register and sets a stored enable flag. In data phase, the written byte is stored into the register that the index selects. The phase flips after every write. Software cannot see the phase directly, so a read of a separate status port forces the phase back to index. This gives software a known starting point before it writes an index/data pair.

The read side has three selectable sources. The index source returns the current index together with the enable flag. The data source returns the selected register. The status source returns the retrace indications. Reads of the index source and the data source have no side effects. A status read resets the phase at the next clock edge. The phase, the index, the flag and the selected register's contents are also driven continuously on dedicated pins for the logic around the block.

Writes are accepted on every cycle and there is no back-pressure. A write strobe takes effect at the next rising edge. Read data is combinational in the same cycle as the read strobe.

Top module: `tgl_regbank`

## Requirements
- R1: After reset the phase is index (toggle_o = 0), the index and flag are 0, and all 32 registers hold 0.
- R2: A write while toggle_o = 0 loads wr_data[4:0] as the index and wr_data[5] as the flag, discards bits 7:6, and sets toggle_o to 1 at the same edge.
- R3: A write while toggle_o = 1 stores all 8 bits of wr_data into the register selected by the index, returns toggle_o to 0, and leaves the index and flag unchanged.
- R4: With rd_en high, rd_sel = 0 returns {2'b00, flag, index[4:0]} and rd_sel = 1 returns the selected register, both in the same cycle. rd_en low or rd_sel = 3 returns 0.
- R5: Reads with rd_sel = 0 or 1, and idle cycles, change neither the phase nor the index, however many there are.
- R6: A read with rd_sel = 2 (status) clears toggle_o at the next edge, whatever the phase was.
- R7: The status read returns bit 0 = hretrace_i OR vretrace_i and bit 3 = vretrace_i, with all other bits 0. The value does not depend on the phase.
- R8: When a write and a status read occur in the same cycle, the write is taken as an index write: the index loads from wr_data and toggle_o ends at 1.
- R9: toggle_o, index_o, flag_o and sel_reg_o always reflect the current phase, index, flag and selected register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the shared index/data port |
| wr_data | input | 8 | Write byte: an index or a register value, depending on the phase |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 2 | Read source: 0 index, 1 data, 2 status, 3 none |
| rd_data | output | 8 | Read result for the current cycle |
| hretrace_i | input | 1 | Horizontal retrace in progress |
| vretrace_i | input | 1 | Vertical retrace in progress |
| toggle_o | output | 1 | Phase: 0 means an index is expected, 1 means data is expected |
| index_o | output | 5 | Current register index |
| flag_o | output | 1 | Stored enable flag from the last index write |
| sel_reg_o | output | 8 | Contents of the selected register |

## Verification
A wrong phase shows up on the very next write: a data byte lands in the index, so both the index read and the data read return unexpected values within one cycle. From then on every later pair is shifted by one write, so the error persists until the next status read. The bench therefore checks toggle_o one cycle after every operation, and it checks the stored contents through data reads after each phase change, status clear and collision. A wrong index shows on the next data read. A register that loses a write shows on its next read-back, so the bench revisits registers after intervening writes.

// File: rtl/tgl_regbank_pkg.sv
package tgl_regbank_pkg;
  typedef enum logic [1:0] {
    SEL_INDEX  = 2'd0,
    SEL_DATA   = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } rd_sel_e;

  localparam int STAT_ANY_BIT = 0;
  localparam int STAT_VRT_BIT = 3;
endpackage

// File: rtl/tgl_phase_ctrl.sv
module tgl_phase_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic stat_rd,
  output logic idx_load,
  output logic data_load,
  output logic toggle
);
  logic phase_q;

  // a status read in the same cycle forces the write to be an index
  assign idx_load  = wr_en && (!phase_q || stat_rd);
  assign data_load = wr_en && phase_q && !stat_rd;
  assign toggle    = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         phase_q <= 1'b0;
    else if (idx_load)  phase_q <= 1'b1;
    else if (data_load) phase_q <= 1'b0;
    else if (stat_rd)   phase_q <= 1'b0;
  end
endmodule

// File: rtl/tgl_index_reg.sv
module tgl_index_reg #(
  parameter int DW = 8,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [IW-1:0] index,
  output logic          flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index <= '0;
      flag  <= 1'b0;
    end else if (load) begin
      index <= din[IW-1:0];
      flag  <= din[IW];
    end
  end
endmodule

// File: rtl/tgl_reg_array.sv
module tgl_reg_array #(
  parameter int DW   = 8,
  parameter int NREG = 32,
  parameter int IW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [IW-1:0] sel,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                        regs[g] <= '0;
      else if (wr_stb && sel == IW'(g))  regs[g] <= din;
    end
  end

  assign dout = regs[sel];
endmodule

// File: rtl/tgl_read_mux.sv
module tgl_read_mux
  import tgl_regbank_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 5
) (
  input  logic          rd_en,
  input  rd_sel_e       sel,
  input  logic [IW-1:0] index,
  input  logic          flag,
  input  logic [DW-1:0] reg_q,
  input  logic          hrt,
  input  logic          vrt,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] stat_byte;

  always_comb begin
    stat_byte = '0;
    stat_byte[STAT_ANY_BIT] = hrt | vrt;
    stat_byte[STAT_VRT_BIT] = vrt;
  end

  always_comb begin
    dout = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_INDEX:  dout = {{(DW-IW-1){1'b0}}, flag, index};
        SEL_DATA:   dout = reg_q;
        SEL_STATUS: dout = stat_byte;
        default:    dout = '0;
      endcase
    end
  end
endmodule

// File: rtl/tgl_regbank.sv
module tgl_regbank
  import tgl_regbank_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [1:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          hretrace_i,
  input  logic          vretrace_i,
  output logic          toggle_o,
  output logic [IW-1:0] index_o,
  output logic          flag_o,
  output logic [DW-1:0] sel_reg_o
);
  rd_sel_e sel_e;
  logic    stat_rd, idx_load, data_load;

  assign sel_e   = rd_sel_e'(rd_sel);
  assign stat_rd = rd_en && (sel_e == SEL_STATUS);

  tgl_phase_ctrl u_phase (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .stat_rd(stat_rd),
    .idx_load(idx_load), .data_load(data_load), .toggle(toggle_o)
  );

  tgl_index_reg #(.DW(DW), .IW(IW)) u_index (
    .clk(clk), .rst_n(rst_n), .load(idx_load), .din(wr_data),
    .index(index_o), .flag(flag_o)
  );

  tgl_reg_array #(.DW(DW), .NREG(NREG), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(data_load), .sel(index_o),
    .din(wr_data), .dout(sel_reg_o)
  );

  tgl_read_mux #(.DW(DW), .IW(IW)) u_rmux (
    .rd_en(rd_en), .sel(sel_e), .index(index_o), .flag(flag_o),
    .reg_q(sel_reg_o), .hrt(hretrace_i), .vrt(vretrace_i), .dout(rd_data)
  );
endmodule

// File: rtl/tgl_regbank_chk.sv
module tgl_regbank_chk #(
  parameter int DW = 8,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          rd_en,
  input logic [1:0]    rd_sel,
  input logic          toggle_o,
  input logic [IW-1:0] index_o,
  input logic          flag_o,
  input logic [DW-1:0] sel_reg_o
);
  logic st;
  assign st = rd_en && (rd_sel == 2'd2);

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !toggle_o && !st) |=> (toggle_o && index_o == $past(wr_data[IW-1:0]) && flag_o == $past(wr_data[IW]))); // R2
  AST_DATA_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && toggle_o && !st) |=> (!toggle_o && $stable(index_o) && sel_reg_o == $past(wr_data))); // R3
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !st) |=> ($stable(toggle_o) && $stable(index_o) && $stable(flag_o))); // R5
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (st && !wr_en) |=> !toggle_o); // R6
  AST_COLLIDE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (st && wr_en) |=> (toggle_o && index_o == $past(wr_data[IW-1:0]))); // R8
endmodule

bind tgl_regbank tgl_regbank_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_sel(rd_sel), .toggle_o(toggle_o), .index_o(index_o),
  .flag_o(flag_o), .sel_reg_o(sel_reg_o)
);

// File: tb/tgl_regbank_bench.sv
module tgl_regbank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_sel = 2'd3;
  logic [7:0] rd_data;
  logic       hretrace_i = 1'b0, vretrace_i = 1'b0;
  logic       toggle_o, flag_o;
  logic [4:0] index_o;
  logic [7:0] sel_reg_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tgl_regbank u_tgl_regbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .hretrace_i(hretrace_i), .vretrace_i(vretrace_i),
    .toggle_o(toggle_o), .index_o(index_o), .flag_o(flag_o),
    .sel_reg_o(sel_reg_o)
  );

  // op: 0 write, 1 read index, 2 read data, 3 read status
  // fields: {op[1:0], wdata[7:0], expected read[7:0], expected toggle after edge}
  localparam int NV = 17;
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 8'h23, 8'h00, 1'b1},
    {2'd1, 8'h00, 8'h23, 1'b1},
    {2'd2, 8'h00, 8'h00, 1'b1},
    {2'd0, 8'hA5, 8'h00, 1'b0},
    {2'd2, 8'h00, 8'hA5, 1'b0},
    {2'd1, 8'h00, 8'h23, 1'b0},
    {2'd0, 8'h1F, 8'h00, 1'b1},
    {2'd3, 8'h00, 8'h00, 1'b0},
    {2'd0, 8'h03, 8'h00, 1'b1},
    {2'd2, 8'h00, 8'hA5, 1'b1},
    {2'd0, 8'h5A, 8'h00, 1'b0},
    {2'd0, 8'h1F, 8'h00, 1'b1},
    {2'd0, 8'hC3, 8'h00, 1'b0},
    {2'd2, 8'h00, 8'hC3, 1'b0},
    {2'd0, 8'hE3, 8'h00, 1'b1},
    {2'd1, 8'h00, 8'h23, 1'b1},
    {2'd2, 8'h00, 8'h5A, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [7:0] wd);
    wr_en   = (op == 2'd0);
    wr_data = wd;
    rd_en   = (op != 2'd0);
    rd_sel  = (op == 2'd1) ? 2'd0 : (op == 2'd2) ? 2'd1 : 2'd2;
  endtask

  task automatic idle();
    wr_en = 1'b0; rd_en = 1'b0; rd_sel = 2'd3; wr_data = '0;
  endtask

  task automatic step(input logic [1:0] op, input logic [7:0] wd);
    @(negedge clk); apply(op, wd);
    @(posedge clk); #1; idle();
  endtask

  task automatic read_now(input logic [1:0] sel, output logic [7:0] v);
    @(negedge clk); idle(); rd_en = 1'b1; rd_sel = sel; #2; v = rd_data;
    @(posedge clk); #1; idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(toggle_o == 1'b0, "R1 toggle", toggle_o, 0);
    check(index_o == 5'd0 && flag_o == 1'b0, "R1 index", {flag_o, index_o}, 0);
    check(sel_reg_o == 8'h00, "R1 reg", sel_reg_o, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); idle(); rd_en = 1'b0; #2;
    check(rd_data == 8'h00, "R4 idle read", rd_data, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i][18:17], VEC[i][16:9]);
      #2;
      if (VEC[i][18:17] == 2'd1 || VEC[i][18:17] == 2'd2)
        check(rd_data == VEC[i][8:1], "R4 table read", rd_data, VEC[i][8:1]);
      else if (VEC[i][18:17] == 2'd3)
        check(rd_data == VEC[i][8:1], "R7 table status", rd_data, VEC[i][8:1]);
      @(posedge clk); #1;
      check(toggle_o == VEC[i][0], "R5 R6 table toggle", toggle_o, VEC[i][0]);
    end
    idle();

    // R2 index field positions and flag; R9 pins
    check(index_o == 5'd3 && flag_o == 1'b1, "R2 index/flag", {flag_o, index_o}, 8'h23);
    check(sel_reg_o == 8'h5A, "R9 sel_reg_o", sel_reg_o, 8'h5A);

    // R3 data write keeps index
    step(2'd0, 8'h66);
    check(toggle_o == 1'b0 && index_o == 5'd3, "R3 index kept", index_o, 3);
    check(sel_reg_o == 8'h66, "R3 stored", sel_reg_o, 8'h66);

    // R5 many reads keep phase
    step(2'd0, 8'h07);
    for (int k = 0; k < 5; k++) begin
      step(2'd1, 8'h00);
      step(2'd2, 8'h00);
    end
    check(toggle_o == 1'b1 && index_o == 5'd7, "R5 hold", {toggle_o, index_o}, 8'h27);

    // R4 sel 3 returns zero, no side effect
    read_now(2'd3, v);
    check(v == 8'h00 && toggle_o == 1'b1, "R4 none sel", v, 0);

    // R7 status bits with retrace inputs
    hretrace_i = 1'b1; vretrace_i = 1'b0;
    read_now(2'd2, v);
    check(v == 8'h01, "R7 hretrace", v, 8'h01);
    check(toggle_o == 1'b0, "R6 clear", toggle_o, 0);
    hretrace_i = 1'b0; vretrace_i = 1'b1;
    read_now(2'd2, v);
    check(v == 8'h09, "R7 vretrace", v, 8'h09);
    hretrace_i = 1'b1;
    read_now(2'd2, v);
    check(v == 8'h09, "R7 both", v, 8'h09);
    hretrace_i = 1'b0; vretrace_i = 1'b0;

    // R8 collision while in data phase
    step(2'd0, 8'h02);
    check(toggle_o == 1'b1, "R8 setup", toggle_o, 1);
    @(negedge clk); idle(); wr_en = 1'b1; wr_data = 8'h09; rd_en = 1'b1; rd_sel = 2'd2;
    @(posedge clk); #1; idle();
    check(toggle_o == 1'b1 && index_o == 5'd9, "R8 collide", {toggle_o, index_o}, 8'h29);
    step(2'd0, 8'h77);
    read_now(2'd1, v);
    check(v == 8'h77, "R8 follow data", v, 8'h77);
    step(2'd0, 8'h02);
    read_now(2'd1, v);
    check(v == 8'h00, "R8 reg2 untouched", v, 0);

    // R1 mid-run reset
    step(2'd0, 8'h03);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check(toggle_o == 1'b0 && index_o == 5'd0, "R1 mid reset", {toggle_o, index_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    step(2'd0, 8'h03);
    read_now(2'd1, v);
    check(v == 8'h00, "R1 regs cleared", v, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule